// File: doc/BRIEF.md
# Serial-Bus PHY Status and Interrupt Registers

This block holds the node-configuration and interrupt state of a serial-bus physical-layer device. It keeps a link-control bit, a contender bit, a 3-bit power class, a watchdog enable and a request for a short arbitrated bus reset. It also keeps four interrupt flags: configuration time-out, cable-power drop, state time-out and port event. Software reaches all of them through one write port and one combinational read port. The self-ID bits go straight to the packet builder. The short-reset request goes to the arbitration logic.

Two reset sources act on the block. The asynchronous active-low hardware reset sets every field to its power-up value. The synchronous bus-reset pulse clears only the short-reset request. All interrupt flags are write-one-to-clear. When the watchdog enable is set and the link layer is inactive, a pending time-out or cable-power interrupt drives a wake output so that the link layer comes back and services it.

Top module: `phy_stat_regs`

## Requirements
- R1: `self_link_active_o` is the AND of the link-control bit (address 0 bit 0) and `lps_i`. The link-control bit does not affect any other output or flag.
- R2: On hardware reset, link-control is 1, contender is 0 and power class is loaded from `pwr_strap_i`. Watchdog enable, the short-reset request and the port enables are 0. The interrupt flags read 4'b0010 (only the cable-power flag is set).
- R3: A `bus_reset_i` pulse clears the short-reset request (address 1 bit 0). Link-control, contender, power class, watchdog enable (address 1 bit 1) and the port enables (address 3) keep their values.
- R4: The jitter field (address 0 bits 7:5) always reads 0, and writes to it have no effect. Address 0 holds power class in bits 4:2, contender in bit 1 and link-control in bit 0.
- R5: Address 2 holds the flags: bit 0 configuration time-out, bit 1 cable power, bit 2 state time-out, bit 3 port event. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged.
- R6: If a set event and a write-one-to-clear reach a flag in the same cycle, the flag ends up set.
- R7: A `cfg_timeout_i` or `state_timeout_i` pulse sets its flag at the next clock edge.
- R8: A high-to-low transition of `cable_pwr_i` sets the cable-power flag 3 clock edges after the input changes, because the input passes through a two-flop synchronizer and then an edge register. A low-to-high transition sets nothing.
- R9: A change in any of a port's four status bits (per port: bit 0 connected, bit 1 bias, bit 2 disabled, bit 3 fault; port p occupies bits 4p+3:4p) sets the port-event flag one edge later, but only if that port's enable bit in address 3 is set.
- R10: A `port_resume_i` pulse on any port sets the port-event flag only while the watchdog enable is set.
- R11: `link_wake_o` is high exactly when the watchdog enable is set, at least one of the configuration time-out, cable-power or state time-out flags is set, and `lps_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| bus_reset_i | input | 1 | Bus-reset event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| pwr_strap_i | input | 3 | Power-class strap, sampled during hardware reset |
| lps_i | input | 1 | Link power status, high when the link layer is active |
| cable_pwr_i | input | 1 | Cable power present, asynchronous |
| cfg_timeout_i | input | 1 | Configuration time-out pulse |
| state_timeout_i | input | 1 | State time-out pulse |
| port_stat_i | input | 12 | Per-port status bits, 4 per port |
| port_resume_i | input | 3 | Per-port resume-start pulse |
| self_link_active_o | output | 1 | Link-active bit for the self-ID packet |
| self_contender_o | output | 1 | Contender bit for the self-ID packet |
| self_pwr_o | output | 3 | Power-class field for the self-ID packet |
| short_reset_req_o | output | 1 | Short arbitrated bus-reset request |
| link_wake_o | output | 1 | Wake request to an inactive link layer |

## Verification
Register writes, the bus-reset pulse, the time-out pulses, resume pulses and port status changes all take effect at the first rising edge after they are driven. The bench therefore drives each stimulus on a falling edge, crosses one rising edge, and samples on the next falling edge. The cable-power path is three edges deep, and the bench checks that the flag is still clear after edges one and two and set after edge three. The readback, the self-ID link bit and the wake output are combinational, so they are sampled 1 ns after their inputs settle.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
  localparam int DW      = 8;
  localparam int AW      = 2;
  localparam int ST_BITS = 4;
  localparam int N_IRQ   = 4;

  typedef enum logic [AW-1:0] {
    A_NODE  = 2'd0,
    A_CTRL  = 2'd1,
    A_IRQ   = 2'd2,
    A_PORTEN = 2'd3
  } reg_addr_e;

  localparam int IRQ_CTO = 0;
  localparam int IRQ_CPS = 1;
  localparam int IRQ_STO = 2;
  localparam int IRQ_PEV = 3;

  localparam logic [N_IRQ-1:0] IRQ_RST = 4'b0010;
endpackage

// File: rtl/cps_fall_det.sv
module cps_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/irq_flag.sv
module irq_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;   // event beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/port_evt_det.sv
module port_evt_det #(
  parameter int NPORTS  = 3,
  parameter int ST_BITS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NPORTS*ST_BITS-1:0] stat_i,
  input  logic [NPORTS-1:0]         en_i,
  input  logic [NPORTS-1:0]         resume_i,
  input  logic                      wdie_i,
  output logic                      evt_o
);
  logic [NPORTS*ST_BITS-1:0] prev_q;
  logic [NPORTS-1:0]         chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stat_i;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign chg[p] = en_i[p] &
        (|(stat_i[p*ST_BITS +: ST_BITS] ^ prev_q[p*ST_BITS +: ST_BITS]));
  end

  assign evt_o = (|chg) | (wdie_i & (|resume_i));
endmodule

// File: rtl/phy_stat_regs.sv
module phy_stat_regs
  import phy_stat_pkg::*;
#(
  parameter int NPORTS = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_reset_i,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic [AW-1:0]             rd_addr_i,
  output logic [DW-1:0]             rd_data_o,
  input  logic [2:0]                pwr_strap_i,
  input  logic                      lps_i,
  input  logic                      cable_pwr_i,
  input  logic                      cfg_timeout_i,
  input  logic                      state_timeout_i,
  input  logic [NPORTS*ST_BITS-1:0] port_stat_i,
  input  logic [NPORTS-1:0]         port_resume_i,
  output logic                      self_link_active_o,
  output logic                      self_contender_o,
  output logic [2:0]                self_pwr_o,
  output logic                      short_reset_req_o,
  output logic                      link_wake_o
);
  logic              link_ctl_q, contender_q, wdie_q, short_q;
  logic [2:0]        pwr_q;
  logic [NPORTS-1:0] port_en_q;
  logic [N_IRQ-1:0]  irq_q, irq_set, irq_clr;
  logic              cps_fall, port_evt;

  wire wr_node = wr_en_i && (wr_addr_i == A_NODE);
  wire wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  wire wr_irq  = wr_en_i && (wr_addr_i == A_IRQ);
  wire wr_pen  = wr_en_i && (wr_addr_i == A_PORTEN);

  // hardware-reset-only fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_ctl_q  <= 1'b1;
      contender_q <= 1'b0;
      pwr_q       <= pwr_strap_i;
      wdie_q      <= 1'b0;
      port_en_q   <= '0;
    end else begin
      if (wr_node) begin
        link_ctl_q  <= wr_data_i[0];
        contender_q <= wr_data_i[1];
        pwr_q       <= wr_data_i[4:2];
      end
      if (wr_ctrl) wdie_q    <= wr_data_i[1];
      if (wr_pen)  port_en_q <= wr_data_i[NPORTS-1:0];
    end
  end

  // bus-reset-cleared field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          short_q <= 1'b0;
    else if (bus_reset_i) short_q <= 1'b0;
    else if (wr_ctrl)     short_q <= wr_data_i[0];
  end

  cps_fall_det #(.SYNC_STAGES(2)) u_cps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(cable_pwr_i),
    .fall_o (cps_fall)
  );

  port_evt_det #(.NPORTS(NPORTS), .ST_BITS(ST_BITS)) u_pev (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stat_i  (port_stat_i),
    .en_i    (port_en_q),
    .resume_i(port_resume_i),
    .wdie_i  (wdie_q),
    .evt_o   (port_evt)
  );

  assign irq_set[IRQ_CTO] = cfg_timeout_i;
  assign irq_set[IRQ_CPS] = cps_fall;
  assign irq_set[IRQ_STO] = state_timeout_i;
  assign irq_set[IRQ_PEV] = port_evt;
  assign irq_clr          = wr_irq ? wr_data_i[N_IRQ-1:0] : '0;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    irq_flag #(.RST_VAL(IRQ_RST[i])) u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (irq_set[i]),
      .clr_i (irq_clr[i]),
      .q_o   (irq_q[i])
    );
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_NODE:   rd_data_o = {3'b000, pwr_q, contender_q, link_ctl_q};
      A_CTRL:   rd_data_o = {{(DW-2){1'b0}}, wdie_q, short_q};
      A_IRQ:    rd_data_o = {{(DW-N_IRQ){1'b0}}, irq_q};
      A_PORTEN: rd_data_o = {{(DW-NPORTS){1'b0}}, port_en_q};
      default:  rd_data_o = '0;
    endcase
  end

  assign self_link_active_o = link_ctl_q & lps_i;
  assign self_contender_o   = contender_q;
  assign self_pwr_o         = pwr_q;
  assign short_reset_req_o  = short_q;
  assign link_wake_o = wdie_q & ~lps_i &
                       (irq_q[IRQ_CTO] | irq_q[IRQ_CPS] | irq_q[IRQ_STO]);
endmodule

// File: rtl/phy_stat_regs_chk.sv
module phy_stat_regs_chk
  import phy_stat_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_reset_i,
  input logic             wr_en_i,
  input logic             lps_i,
  input logic             cfg_timeout_i,
  input logic             state_timeout_i,
  input logic [AW-1:0]    rd_addr_i,
  input logic [DW-1:0]    rd_data_o,
  input logic             self_link_active_o,
  input logic [2:0]       self_pwr_o,
  input logic             short_reset_req_o,
  input logic             link_wake_o,
  input logic [N_IRQ-1:0] irq_q
);
  p_link_needs_lps_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_link_active_o |-> lps_i);

  p_bus_rst_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !short_reset_req_o);

  p_pwr_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_i && !wr_en_i) |=> $stable(self_pwr_o));

  p_jitter_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == A_NODE) |-> (rd_data_o[7:5] == 3'b000));

  p_cto_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_timeout_i |=> irq_q[IRQ_CTO]);

  p_sto_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_timeout_i |=> irq_q[IRQ_STO]);

  p_wake_inactive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_wake_o |-> (!lps_i && (irq_q[IRQ_CTO] || irq_q[IRQ_CPS] || irq_q[IRQ_STO])));
endmodule

bind phy_stat_regs phy_stat_regs_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .bus_reset_i       (bus_reset_i),
  .wr_en_i           (wr_en_i),
  .lps_i             (lps_i),
  .cfg_timeout_i     (cfg_timeout_i),
  .state_timeout_i   (state_timeout_i),
  .rd_addr_i         (rd_addr_i),
  .rd_data_o         (rd_data_o),
  .self_link_active_o(self_link_active_o),
  .self_pwr_o        (self_pwr_o),
  .short_reset_req_o (short_reset_req_o),
  .link_wake_o       (link_wake_o),
  .irq_q             (irq_q)
);

// File: tb/phy_stat_regs_bench.sv
`timescale 1ns/1ps
module phy_stat_regs_bench;
  localparam int NP = 3;

  logic        clk_i = 0, rst_ni = 0, bus_reset_i = 0, wr_en_i = 0;
  logic [1:0]  wr_addr_i = 0, rd_addr_i = 0;
  logic [7:0]  wr_data_i = 0, rd_data_o;
  logic [2:0]  pwr_strap_i = 3'b101;
  logic        lps_i = 0, cable_pwr_i = 1, cfg_timeout_i = 0, state_timeout_i = 0;
  logic [NP*4-1:0] port_stat_i = '0;
  logic [NP-1:0]   port_resume_i = '0;
  logic        self_link_active_o, self_contender_o, short_reset_req_o, link_wake_o;
  logic [2:0]  self_pwr_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] d;

  always #5 clk_i = ~clk_i;

  phy_stat_regs #(.NPORTS(NP)) u_phy_stat_regs (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = v;
    step();
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr_i = a; #1; v = rd_data_o;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R2 reset values
    rd(0, d); chk("R2 node", d, 8'h15);
    rd(1, d); chk("R2 ctrl", d, 8'h00);
    rd(2, d); chk("R2 irq", d, 8'h02);
    rd(3, d); chk("R2 porten", d, 8'h00);
    chk("R2 wake", {7'b0, link_wake_o}, 8'h00);

    // R1 AND sweep
    for (int lc = 0; lc < 2; lc++)
      for (int lp = 0; lp < 2; lp++) begin
        wr(0, {3'b000, 3'b101, 1'b0, lc[0]});
        lps_i = lp[0]; #1;
        chk("R1 link_active", {7'b0, self_link_active_o}, {7'b0, lc[0] & lp[0]});
      end
    lps_i = 0;

    // R4 jitter ignored
    wr(0, 8'hEF); rd(0, d); chk("R4 jitter", d, 8'h0F);
    chk("R4 contender", {7'b0, self_contender_o}, 8'h01);
    chk("R4 pwr", {5'b0, self_pwr_o}, 8'h03);

    // R3 bus reset
    wr(3, 8'h05); wr(1, 8'h03);
    chk("R3 short set", {7'b0, short_reset_req_o}, 8'h01);
    bus_reset_i = 1; step(); bus_reset_i = 0;
    chk("R3 short cleared", {7'b0, short_reset_req_o}, 8'h00);
    rd(1, d); chk("R3 wdie kept", d, 8'h02);
    rd(0, d); chk("R3 node kept", d, 8'h0F);
    rd(3, d); chk("R3 porten kept", d, 8'h05);
    wr(1, 8'h00); wr(3, 8'h00);

    // R5 W1C
    wr(2, 8'h00); rd(2, d); chk("R5 write0", d, 8'h02);
    wr(2, 8'h02); rd(2, d); chk("R5 clear cps", d, 8'h00);

    // R7 timeouts
    cfg_timeout_i = 1; step(); cfg_timeout_i = 0;
    rd(2, d); chk("R7 cto", d, 8'h01);
    state_timeout_i = 1; step(); state_timeout_i = 0;
    rd(2, d); chk("R7 sto", d, 8'h05);
    wr(2, 8'h01); rd(2, d); chk("R5 clear cto only", d, 8'h04);

    // R6 event beats clear
    state_timeout_i = 1; wr(2, 8'h0F); state_timeout_i = 0;
    rd(2, d); chk("R6 sto wins", d, 8'h04);
    wr(2, 8'h0F); rd(2, d); chk("R5 all clear", d, 8'h00);

    // R8 cable power
    cable_pwr_i = 0;
    step(); rd(2, d); chk("R8 edge1", d, 8'h00);
    step(); rd(2, d); chk("R8 edge2", d, 8'h00);
    step(); rd(2, d); chk("R8 edge3", d, 8'h02);
    wr(2, 8'h02);
    cable_pwr_i = 1;
    repeat (4) step();
    rd(2, d); chk("R8 rise ignored", d, 8'h00);

    // R9 port status sweep
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < 4; b++)
        for (int en = 0; en < 2; en++) begin
          wr(3, en[0] ? 8'(1 << p) : 8'h00);
          wr(2, 8'h0F);
          port_stat_i[p*4+b] = ~port_stat_i[p*4+b];
          step();
          rd(2, d); chk("R9 port change", d, {4'b0, en[0], 3'b000});
        end
    wr(3, 8'h00); wr(2, 8'h0F);

    // R10 resume
    for (int w = 0; w < 2; w++)
      for (int p = 0; p < NP; p++) begin
        wr(1, {6'b0, w[0], 1'b0});
        wr(2, 8'h0F);
        port_resume_i = NP'(1 << p); step(); port_resume_i = '0;
        rd(2, d); chk("R10 resume", d, {4'b0, w[0], 3'b000});
      end

    // R11 wake sweep
    for (int w = 0; w < 2; w++)
      for (int f = 0; f < 8; f++)
        for (int lp = 0; lp < 2; lp++) begin
          wr(1, {6'b0, w[0], 1'b0});
          wr(2, 8'h0F);
          lps_i = lp[0];
          if (f[0]) begin cfg_timeout_i = 1; step(); cfg_timeout_i = 0; end
          if (f[2]) begin state_timeout_i = 1; step(); state_timeout_i = 0; end
          if (f[1]) begin
            cable_pwr_i = 0; repeat (3) step(); cable_pwr_i = 1; repeat (3) step();
          end
          rd(2, d); chk("R11 flags", d, {5'b0, f[2:0]});
          chk("R11 wake", {7'b0, link_wake_o},
              {7'b0, w[0] & (f != 0) & ~lp[0]});
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule